// File: doc/BRIEF.md
# SPI Panel Register Initialization Sequencer

This block brings an LCD panel into a working configuration over a write-only SPI link. A single start pulse makes it walk a fixed, built-in list of 24 register index/value pairs in order. Each register write goes out as two separate chip-select windows of 24 bits each. The first window is an index frame and the second is a value frame. When the last value frame has finished, a one-cycle done pulse is given.

Independently of the sequencer, the block holds the panel-enable line. Single-cycle enable and disable request pulses set and clear it. The SPI clock is derived from the system clock. The parameter `HALF_DIV` sets each SCLK half period in system cycles. The parameter `CS_GAP` sets the number of SCLK periods for which chip select stays high between frames.

Top module: `panel_init_seq`

## Requirements
- R1: An index frame is 24 bits sent MSB first: byte 0x70, then 0x00, then the register index with bit 7 forced to 0.
- R2: A value frame is 24 bits sent MSB first: byte 0x72, then the value's bits 15..8, then bits 7..0.
- R3: A run sends the 24 table pairs in this fixed order (index=value): 01=6300 02=0200 03=0177 04=04C7 05=FFC0 06=E806 0A=4008 0B=0000 0D=0030 0E=2800 0F=0000 16=9F80 17=0A0F 1E=00C1 30=0300 31=0007 32=0000 33=0000 34=0707 35=0004 36=0302 37=0202 3A=0A0D 3B=0806. For each pair the index frame goes first and the value frame follows, giving 48 frames in total.
- R4: Every frame has its own chip-select window. Between two frames of a run, cs_n stays high for exactly CS_GAP*2*HALF_DIV system cycles. With the default values this is two SCLK periods.
- R5: SPI mode 0 is used. SCLK is low when each frame starts and each SCLK level lasts HALF_DIV cycles. MOSI changes only while SCLK is low and holds steady while SCLK is high.
- R6: Whenever cs_n is high, sclk_o and mosi_o are both low.
- R7: When a start pulse arrives while the block is idle, busy_o is high in the following cycle. A start pulse that arrives while busy_o is high has no effect on the frames or on their timing.
- R8: done_o is high for exactly one cycle, and busy_o is low in that same cycle. The done cycle comes 48*48*HALF_DIV + 47*CS_GAP*2*HALF_DIV cycles after the clock edge that accepted the start pulse.
- R9: panel_en_o goes high one cycle after an enable pulse and low one cycle after a disable pulse. If both pulses arrive in the same cycle, the disable pulse wins.
- R10: While reset is active and just after it: cs_n_o=1, sclk_o=0, mosi_o=0, busy_o=0, done_o=0, panel_en_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts a table run |
| en_req_i | input | 1 | Pulse that sets the panel enable |
| dis_req_i | input | 1 | Pulse that clears the panel enable |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI serial data out |
| cs_n_o | output | 1 | SPI chip select, active low |
| panel_en_o | output | 1 | Panel enable line |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run finishes |

## Verification
Every result has a known due time. Busy and panel enable respond one cycle after their request. Done appears exactly 48*48*HALF_DIV + 47 gap lengths after the accepted start, and the bench counts rising edges up to that cycle, so an early, late or restarted run fails the check. The bench drives inputs and samples outputs on the falling clock edge, and per-cycle monitors measure each SCLK level, each chip-select gap and the idle line levels. A receiver clocked by SCLK collects every frame, and the bench compares the frames against a table it holds itself.

// File: rtl/panel_init_seq.sv
module panel_init_seq #(
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic en_req_i,
  input  logic dis_req_i,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_n_o,
  output logic panel_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int N_ENT   = 24;
  localparam int F_BITS  = 24;
  localparam int GAP_CYC = CS_GAP * 2 * HALF_DIV;
  localparam int DW      = $clog2(HALF_DIV + 1);
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int EW      = $clog2(N_ENT);
  localparam int BW      = $clog2(F_BITS);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t                state;
  logic [DW-1:0]      div_cnt;
  logic [GW-1:0]      gap_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [EW-1:0]      ent;
  logic               is_val;
  logic [F_BITS-1:0]  shreg;
  logic               sclk_r;
  logic               done_r;
  logic               en_r;

  function automatic logic [22:0] table_row(input logic [EW-1:0] i);
    case (i)
      5'd0:    table_row = {7'h01, 16'h6300};
      5'd1:    table_row = {7'h02, 16'h0200};
      5'd2:    table_row = {7'h03, 16'h0177};
      5'd3:    table_row = {7'h04, 16'h04C7};
      5'd4:    table_row = {7'h05, 16'hFFC0};
      5'd5:    table_row = {7'h06, 16'hE806};
      5'd6:    table_row = {7'h0A, 16'h4008};
      5'd7:    table_row = {7'h0B, 16'h0000};
      5'd8:    table_row = {7'h0D, 16'h0030};
      5'd9:    table_row = {7'h0E, 16'h2800};
      5'd10:   table_row = {7'h0F, 16'h0000};
      5'd11:   table_row = {7'h16, 16'h9F80};
      5'd12:   table_row = {7'h17, 16'h0A0F};
      5'd13:   table_row = {7'h1E, 16'h00C1};
      5'd14:   table_row = {7'h30, 16'h0300};
      5'd15:   table_row = {7'h31, 16'h0007};
      5'd16:   table_row = {7'h32, 16'h0000};
      5'd17:   table_row = {7'h33, 16'h0000};
      5'd18:   table_row = {7'h34, 16'h0707};
      5'd19:   table_row = {7'h35, 16'h0004};
      5'd20:   table_row = {7'h36, 16'h0302};
      5'd21:   table_row = {7'h37, 16'h0202};
      5'd22:   table_row = {7'h3A, 16'h0A0D};
      5'd23:   table_row = {7'h3B, 16'h0806};
      default: table_row = '0;
    endcase
  endfunction

  function automatic logic [F_BITS-1:0] frame_of(input logic [EW-1:0] i, input logic v);
    logic [22:0] row;
    row = table_row(i);
    frame_of = v ? {8'h72, row[15:0]} : {8'h70, 8'h00, 1'b0, row[22:16]};
  endfunction

  wire tick       = (div_cnt == DW'(HALF_DIV - 1));
  wire last_bit   = (bit_cnt == BW'(F_BITS - 1));
  wire last_entry = (ent == EW'(N_ENT - 1));
  wire gap_end    = (gap_cnt == GW'(GAP_CYC - 1));

  assign busy_o     = (state != S_IDLE);
  assign cs_n_o     = (state != S_SHIFT);
  assign mosi_o     = (state == S_SHIFT) & shreg[F_BITS-1];
  assign sclk_o     = sclk_r;
  assign done_o     = done_r;
  assign panel_en_o = en_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      div_cnt <= '0;
      gap_cnt <= '0;
      bit_cnt <= '0;
      ent     <= '0;
      is_val  <= 1'b0;
      shreg   <= '0;
      sclk_r  <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            state   <= S_SHIFT;
            ent     <= '0;
            is_val  <= 1'b0;
            shreg   <= frame_of('0, 1'b0);
            div_cnt <= '0;
            bit_cnt <= '0;
            sclk_r  <= 1'b0;
          end
        end
        S_SHIFT: begin
          if (!tick) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (!sclk_r) begin
              sclk_r <= 1'b1;
            end else begin
              sclk_r <= 1'b0;
              if (!last_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[F_BITS-2:0], 1'b0};
              end else if (is_val && last_entry) begin
                state  <= S_IDLE;
                done_r <= 1'b1;
              end else begin
                state   <= S_GAP;
                gap_cnt <= '0;
                is_val  <= ~is_val;
                if (is_val) ent <= ent + 1'b1;
              end
            end
          end
        end
        S_GAP: begin
          if (gap_end) begin
            state   <= S_SHIFT;
            shreg   <= frame_of(ent, is_val);
            bit_cnt <= '0;
            div_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_r <= 1'b0;
    else if (dis_req_i) en_r <= 1'b0;
    else if (en_req_i)  en_r <= 1'b1;
  end

  p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (!sclk_o && !mosi_o));

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && !cs_n_o) |-> $stable(mosi_o));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req_i && !dis_req_i) |=> panel_en_o);

  p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req_i |=> !panel_en_o);
endmodule

// File: tb/panel_init_seq_tb.sv
module panel_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int CS_GAP     = 2;
  localparam int GAP_CYC    = CS_GAP * 2 * HALF_DIV;
  localparam int RUN_CYC    = 48 * 48 * HALF_DIV + 47 * GAP_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, en_req_i = 1'b0, dis_req_i = 1'b0;
  logic sclk_o, mosi_o, cs_n_o, panel_en_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  panel_init_seq #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .en_req_i(en_req_i),
    .dis_req_i(dis_req_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .panel_en_o(panel_en_o), .busy_o(busy_o), .done_o(done_o));

  function automatic logic [22:0] exp_row(input int i);
    logic [22:0] t [24];
    t = '{ {7'h01,16'h6300}, {7'h02,16'h0200}, {7'h03,16'h0177}, {7'h04,16'h04C7},
           {7'h05,16'hFFC0}, {7'h06,16'hE806}, {7'h0A,16'h4008}, {7'h0B,16'h0000},
           {7'h0D,16'h0030}, {7'h0E,16'h2800}, {7'h0F,16'h0000}, {7'h16,16'h9F80},
           {7'h17,16'h0A0F}, {7'h1E,16'h00C1}, {7'h30,16'h0300}, {7'h31,16'h0007},
           {7'h32,16'h0000}, {7'h33,16'h0000}, {7'h34,16'h0707}, {7'h35,16'h0004},
           {7'h36,16'h0302}, {7'h37,16'h0202}, {7'h3A,16'h0A0D}, {7'h3B,16'h0806} };
    exp_row = t[i];
  endfunction

  // SPI receiver
  logic [23:0] frames [256];
  int          frame_len [256];
  int          nframes = 0;
  logic [23:0] rx = '0;
  int          nb = 0;
  always @(posedge sclk_o or posedge cs_n_o) begin
    if (cs_n_o === 1'b1) begin
      if (nb > 0) begin
        if (nframes < 256) begin
          frames[nframes]    = rx;
          frame_len[nframes] = nb;
        end
        nframes = nframes + 1;
        nb = 0;
      end
    end else if (cs_n_o === 1'b0) begin
      rx = {rx[22:0], mosi_o};
      nb = nb + 1;
    end
  end

  // Per-cycle line monitor
  int   idle_bad = 0, mosi_bad = 0, half_bad = 0;
  int   run = 0, gap_run = 0, gap_min = 1000000, gap_max = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n_o === 1'b0) begin
        if (prev_cs === 1'b0 && sclk_o !== prev_sclk) begin
          if (run != HALF_DIV) half_bad = half_bad + 1;
          run = 1;
        end else if (prev_cs === 1'b0) begin
          run = run + 1;
        end else begin
          run = 1;
          if (sclk_o !== 1'b0) half_bad = half_bad + 1;
        end
        if (sclk_o && prev_sclk && prev_cs === 1'b0 && mosi_o !== prev_mosi)
          mosi_bad = mosi_bad + 1;
        if (prev_cs === 1'b1 && gap_run > 0) begin
          if (gap_run < gap_min) gap_min = gap_run;
          if (gap_run > gap_max) gap_max = gap_run;
        end
        gap_run = 0;
      end else begin
        if (sclk_o !== 1'b0 || mosi_o !== 1'b0) idle_bad = idle_bad + 1;
        gap_run = busy_o ? gap_run + 1 : 0;
      end
    end
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
    prev_cs   = cs_n_o;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "cs_n in reset", int'(cs_n_o), 1);
    check("R10", "sclk in reset", int'(sclk_o), 0);
    check("R10", "mosi in reset", int'(mosi_o), 0);
    check("R10", "busy in reset", int'(busy_o), 0);
    check("R10", "panel_en in reset", int'(panel_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "done after reset", int'(done_o), 0);
    check("R10", "cs_n after reset", int'(cs_n_o), 1);
  endtask

  // Full run; extra_start pulses start repeatedly while busy (R7)
  task automatic t_run(input bit extra_start);
    int base, cyc, done_cnt, i;
    bit seen;
    base = nframes;
    gap_min = 1000000;
    gap_max = 0;
    start_i = 1'b1;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7", "busy one cycle after start", int'(busy_o), 1);
    seen = 0;
    done_cnt = 0;
    while (!seen && cyc < RUN_CYC + 100) begin
      if (extra_start && (cyc % 97 == 5)) start_i = 1'b1;
      else start_i = 1'b0;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done_o) begin
        seen = 1;
        done_cnt++;
        check("R8", "busy low with done", int'(busy_o), 0);
      end
    end
    start_i = 1'b0;
    check("R8", "done cycle after start", cyc, RUN_CYC + 1);
    @(negedge clk);
    check("R8", "done lasts one cycle", int'(done_o), 0);
    check("R8", "single done", done_cnt, 1);
    check("R3", "frame count", nframes - base, 48);
    for (i = 0; i < 24; i++) begin
      logic [22:0] r;
      r = exp_row(i);
      check("R1", $sformatf("index frame %0d", i), int'(frames[base + 2*i]),
            int'({8'h70, 8'h00, 1'b0, r[22:16]}));
      check("R2", $sformatf("value frame %0d", i), int'(frames[base + 2*i + 1]),
            int'({8'h72, r[15:0]}));
      check("R4", $sformatf("bits in index frame %0d", i), frame_len[base + 2*i], 24);
    end
    check("R4", "shortest cs gap", gap_min, GAP_CYC);
    check("R4", "longest cs gap", gap_max, GAP_CYC);
    check("R4", "gap at least two sclk periods", int'(gap_min >= 4 * HALF_DIV), 1);
    check("R5", "sclk half period errors", half_bad, 0);
    check("R5", "mosi moved while sclk high", mosi_bad, 0);
    check("R6", "idle line errors", idle_bad, 0);
    repeat (20) @(negedge clk);
    check("R7", "no frames after finish", nframes - base, 48);
    check("R7", "idle after finish", int'(busy_o), 0);
  endtask

  task automatic t_enable;
    en_req_i = 1'b1;
    @(negedge clk);
    en_req_i = 1'b0;
    check("R9", "enable sets", int'(panel_en_o), 1);
    repeat (3) @(negedge clk);
    check("R9", "enable holds", int'(panel_en_o), 1);
    dis_req_i = 1'b1;
    @(negedge clk);
    dis_req_i = 1'b0;
    check("R9", "disable clears", int'(panel_en_o), 0);
    en_req_i = 1'b1;
    @(negedge clk);
    en_req_i = 1'b0;
    check("R9", "enable again", int'(panel_en_o), 1);
    en_req_i = 1'b1;
    dis_req_i = 1'b1;
    @(negedge clk);
    en_req_i = 1'b0;
    dis_req_i = 1'b0;
    check("R9", "disable wins over enable", int'(panel_en_o), 0);
    en_req_i = 1'b1;
    dis_req_i = 1'b1;
    @(negedge clk);
    en_req_i = 1'b0;
    dis_req_i = 1'b0;
    check("R9", "both while low stays low", int'(panel_en_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_run(1'b0);
    t_enable();
    t_run(1'b1);
    en_req_i = 1'b1;
    @(negedge clk);
    en_req_i = 1'b0;
    t_run(1'b0);
    check("R9", "enable unaffected by run", int'(panel_en_o), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule